// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Master

This block is the host-side controller for a three-wire register bus. The bus has a serial clock, a shared bidirectional data line and a latch-enable strobe. A client hands the block a read or write command through a valid/ready request port. The block turns the command into a serial frame. Each frame starts with a fixed 3-bit start pattern, then a direction bit, a 5-bit register address and a 16-bit data word.

On a write, the master drives the whole frame and then pulses the latch strobe so the peripheral stores the word. On a read, the master drives only the start pattern, direction and address. It then releases the data line and shifts in 16 bits supplied by the peripheral. The strobe marks the point where the read word is captured. The master drives the line again only after a guard period, so the two sides never drive it at the same time. Every frame ends with a one-cycle done pulse; for a read the returned word comes with it.

The data line appears at the ports as an output value, an output enable and an input, so the pad or a bench can resolve it. The serial clock rate comes from a division parameter.

Top module: `srb_master`

## Requirements
- R1: Every frame sends the start pattern 101 (binary) first, then the direction bit, then address bits 4 down to 0. On a write these are followed by data bits 15 down to 0. All fields go out most significant bit first, one bit per serial clock period.
- R2: The direction bit is 0 for a write and 1 for a read.
- R3: The master changes its data output and output enable only in the cycle where the serial clock falls, or when it accepts a command while the clock is low. Both stay constant while the serial clock is high.
- R4: After data bit 0 of a write, the latch strobe goes high on a falling clock edge and stays high for exactly one serial clock period. The peripheral stores the written word on the rising edge inside that period.
- R5: On a read, the output enable drops on the falling edge that ends the last address bit. It stays low through the latch period and through one further rising edge after the strobe falls. It returns high on the falling edge that ends the frame.
- R6: On a read, the master samples the data line on the 16 falling edges that follow the address. It captures the assembled word on the falling edge that ends the strobe period and presents it on the read-data output together with the done pulse.
- R7: A read always transfers exactly 16 data bits, and bit 15 and bit 0 of the returned word are the first and last bits the peripheral sent.
- R8: One serial clock period lasts CLK_DIV system clocks (values below 4 are raised to 4). The clock is high for CLK_DIV - CLK_DIV/2 of them and stays low whenever the block is idle.
- R9: The ready output is high only while idle. A command is accepted in a cycle where valid and ready are both high, and ready drops in the cycle that follows. Each accepted command yields exactly one done pulse, one cycle wide.
- R10: A write frame has 26 rising serial clock edges: 25 bit periods plus the latch period. A read frame has 27: 25 bit periods, the latch period and the guard period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Block idle and able to accept a command |
| req_rd | input | 1 | 1 for read, 0 for write |
| req_addr | input | 5 | Target register address |
| req_wdata | input | 16 | Word to write |
| rsp_done | output | 1 | One-cycle pulse at the end of each frame |
| rsp_rdata | output | 16 | Word returned by the last read |
| sclk | output | 1 | Serial clock |
| sle | output | 1 | Latch-enable strobe |
| sdat_o | output | 1 | Value driven on the data line |
| sdat_oe | output | 1 | Data line output enable |
| sdat_i | input | 1 | Value seen on the data line |

## Verification
The bench attaches a behavioural peripheral to the resolved data line. It runs writes of all-ones, all-zeros and mixed words to the lowest, highest and middle addresses, so each field position and the bit order of the frame show up separately. Reads target preset registers whose top and bottom bits are both set, and registers just rewritten. A wrong sample edge, a wrong capture point or a swapped bit order therefore gives a different word. Write-then-read on the same address, and commands issued back to back, separate the handling of the turnaround and the guard period from the plain write path. Each frame also has its rising edges counted and its clock-high cycles measured.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int HDR_W   = 3;
  localparam logic [HDR_W-1:0] HDR_VAL = 3'b101;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int CMD_W   = HDR_W + 1 + ADDR_W;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int LATCH_SLOT = FRAME_W;
  localparam int GUARD_SLOT = FRAME_W + 1;
  localparam int SLOT_W  = $clog2(GUARD_SLOT + 1);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_t;
endpackage

// File: rtl/srb_sclk_gen.sv
module srb_sclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;

  assign rise_tick = run && (cnt_q == CW'(HALF - 1));
  assign fall_tick = run && (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (fall_tick) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (rise_tick) sclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/srb_rx_capture.sv
module srb_rx_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         cap_en,
  input  logic         sdat_i,
  output logic [W-1:0] rdata
);
  logic [W-1:0] shreg_q, shreg_d;
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    shreg_d = shreg_q;
    hold_d  = hold_q;
    if (shift_en) shreg_d = {shreg_q[W-2:0], sdat_i};
    if (cap_en)   hold_d  = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      hold_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      hold_q  <= hold_d;
    end
  end

  assign rdata = hold_q;
endmodule

// File: rtl/srb_frame_seq.sv
module srb_frame_seq
  import srb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              fall_tick,
  output logic              req_ready,
  output logic              run,
  output logic              sdat_o,
  output logic              sdat_oe,
  output logic              sle,
  output logic              shift_en,
  output logic              cap_en,
  output logic              done
);
  seq_state_t         state_q, state_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               rd_q, rd_d;
  logic               dout_q, dout_d;
  logic               oe_q, oe_d;
  logic               sle_q, sle_d;
  logic               done_q, done_d;
  logic [SLOT_W-1:0]  last_slot;
  logic               in_rx_window;

  assign last_slot    = rd_q ? SLOT_W'(GUARD_SLOT) : SLOT_W'(LATCH_SLOT);
  assign in_rx_window = (slot_q >= SLOT_W'(CMD_W)) && (slot_q < SLOT_W'(FRAME_W));

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    frame_d = frame_q;
    rd_d    = rd_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    sle_d   = sle_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_XFER;
          slot_d  = '0;
          rd_d    = req_rd;
          frame_d = {HDR_VAL, req_rd, req_addr, (req_rd ? {DATA_W{1'b0}} : req_wdata)};
          dout_d  = HDR_VAL[HDR_W-1];
          oe_d    = 1'b1;
          sle_d   = 1'b0;
        end
      end
      ST_XFER: begin
        if (fall_tick) begin
          if (slot_q == last_slot) begin
            state_d = ST_IDLE;
            dout_d  = 1'b0;
            oe_d    = 1'b1;
            sle_d   = 1'b0;
            done_d  = 1'b1;
          end else begin
            slot_d  = slot_q + 1'b1;
            frame_d = {frame_q[FRAME_W-2:0], 1'b0};
            dout_d  = frame_q[FRAME_W-2];
            if (rd_q && (slot_q == SLOT_W'(CMD_W - 1))) oe_d = 1'b0;
            if (slot_q == SLOT_W'(FRAME_W - 1)) sle_d = 1'b1;
            if (slot_q == SLOT_W'(LATCH_SLOT))  sle_d = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b1;
      sle_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
      rd_q    <= rd_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      sle_q   <= sle_d;
      done_q  <= done_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign run       = (state_q == ST_XFER);
  assign sdat_o    = dout_q;
  assign sdat_oe   = oe_q;
  assign sle       = sle_q;
  assign done      = done_q;
  assign shift_en  = run && fall_tick && rd_q && in_rx_window;
  assign cap_en    = run && fall_tick && rd_q && (slot_q == SLOT_W'(LATCH_SLOT));
endmodule

// File: rtl/srb_master.sv
module srb_master
  import srb_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sclk,
  output logic              sle,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic              sdat_i
);
  localparam int DIV_EFF = (CLK_DIV < 4) ? 4 : CLK_DIV;

  logic rst_meta_q, rst_sync_q;
  logic run, rise_tick, fall_tick, shift_en, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  srb_sclk_gen #(.DIV(DIV_EFF)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .run       (run),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  srb_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_valid (req_valid),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .fall_tick (fall_tick),
    .req_ready (req_ready),
    .run       (run),
    .sdat_o    (sdat_o),
    .sdat_oe   (sdat_oe),
    .sle       (sle),
    .shift_en  (shift_en),
    .cap_en    (cap_en),
    .done      (rsp_done)
  );

  srb_rx_capture #(.W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .shift_en (shift_en),
    .cap_en   (cap_en),
    .sdat_i   (sdat_i),
    .rdata    (rsp_rdata)
  );

  logic unused_rise;
  assign unused_rise = rise_tick;
endmodule

// File: rtl/srb_master_chk.sv
module srb_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic sclk,
  input logic sle,
  input logic sdat_o,
  input logic sdat_oe
);
  // R3: line value and enable hold while the serial clock is high
  p_sdat_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(sdat_o) && $stable(sdat_oe)));

  // R4: strobe rises together with a falling serial clock edge
  p_sle_rise_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sle) |-> $fell(sclk));

  // R4: strobe drops together with a falling serial clock edge
  p_sle_fall_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sle) |-> $fell(sclk));

  // R5: master retakes the line only at the falling edge that ends the frame
  p_oe_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> (req_ready && $fell(sclk)));

  // R8: clock idles low
  p_sclk_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !sclk);

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9: ready drops after an accepted command
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind srb_master srb_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .sclk      (sclk),
  .sle       (sle),
  .sdat_o    (sdat_o),
  .sdat_oe   (sdat_oe)
);

// File: tb/srb_master_bench.sv
module srb_master_bench;
  localparam int DIV  = 5;
  localparam int HIGH = DIV - DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_rd = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        sclk, sle, sdat_o, sdat_oe, sdat_i;

  logic p_drv = 1'b0;
  logic p_bit = 1'b0;
  assign sdat_i = sdat_oe ? sdat_o : (p_drv ? p_bit : 1'b1);

  srb_master #(.CLK_DIV(DIV)) u_srb_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sclk(sclk), .sle(sle),
    .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int done_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit          rd;
    logic [4:0]  addr;
    logic [15:0] data;
  } item_t;
  item_t exp_q[$];

  logic [15:0] pmem   [32];
  logic [15:0] shadow [32];

  function automatic logic [15:0] preset(input int i);
    if (i == 17) return 16'h8001;
    return 16'((i * 16'h0913) ^ 16'h5A3C);
  endfunction

  // behavioural peripheral
  int          p_cnt = 0;
  int          p_rises = 0;
  bit          p_skip = 0;
  bit          p_turn_ok = 1;
  logic [2:0]  p_hdr = '0;
  logic        p_rw = 1'b0;
  logic [4:0]  p_addr = '0;
  logic [15:0] p_data = '0;
  logic [2:0]  f_hdr = '0;
  logic        f_rw = 1'b0;
  logic [4:0]  f_addr = '0;
  logic [15:0] f_data = '0;
  int          f_rises = 0;
  bit          f_turn_ok = 0;

  task finish_frame();
    f_hdr = p_hdr; f_rw = p_rw; f_addr = p_addr; f_data = p_data;
    f_rises = p_rises; f_turn_ok = p_turn_ok;
    p_cnt = 0; p_rises = 0; p_turn_ok = 1; p_hdr = '0;
  endtask

  always @(posedge sclk) begin
    p_rises++;
    if (p_skip) begin
      p_turn_ok &= (!sdat_oe && !sle);
      p_skip = 0;
      finish_frame();
    end else if (sle) begin
      if (!p_rw) pmem[p_addr] = p_data;
      else p_turn_ok &= !sdat_oe;
      p_drv = 1'b0;
      if (p_rw) p_skip = 1;
      else finish_frame();
    end else begin
      if (p_cnt < 3) p_hdr = {p_hdr[1:0], sdat_i};
      else if (p_cnt == 3) p_rw = sdat_i;
      else if (p_cnt < 9) p_addr = {p_addr[3:0], sdat_i};
      else if (!p_rw) p_data = {p_data[14:0], sdat_i};
      else begin
        if (p_cnt == 9) p_turn_ok &= !sdat_oe;
        p_drv = 1'b1;
        p_bit = pmem[p_addr][24 - p_cnt];
      end
      p_cnt++;
    end
  end

  // scoreboard monitor
  int   hi_cnt = 0;
  int   r3_bad = 0;
  logic prev_sclk = 1'b0, prev_o = 1'b0, prev_oe = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk) hi_cnt++;
      if (sclk && prev_sclk && (sdat_o !== prev_o || sdat_oe !== prev_oe)) r3_bad++;
      prev_sclk = sclk; prev_o = sdat_o; prev_oe = sdat_oe;
      if (rsp_done) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "done without command", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(f_hdr == 3'b101, "R1", "start pattern", f_hdr, 3'b101);
          check(f_addr == it.addr, "R1", "address field", f_addr, it.addr);
          check(f_rw == it.rd, "R2", "direction bit", f_rw, it.rd);
          check(r3_bad == 0, "R3", "line changed while clock high", r3_bad, 0);
          check(hi_cnt == f_rises * HIGH, "R8", "clock high cycles", hi_cnt, f_rises * HIGH);
          if (it.rd) begin
            check(rsp_rdata == it.data, "R6", "read word", rsp_rdata, it.data);
            check(rsp_rdata[15] == it.data[15] && rsp_rdata[0] == it.data[0],
                  "R7", "end bits of read word", rsp_rdata, it.data);
            check(f_turn_ok, "R5", "line released through turnaround", f_turn_ok, 1);
            check(f_rises == 27, "R10", "read frame rising edges", f_rises, 27);
          end else begin
            check(f_data == it.data, "R1", "write data field", f_data, it.data);
            check(pmem[it.addr] == it.data, "R4", "word latched by peripheral", pmem[it.addr], it.data);
            check(f_rises == 26, "R10", "write frame rising edges", f_rises, 26);
          end
        end
        hi_cnt = 0;
        r3_bad = 0;
      end
    end
  end

  task automatic send(input bit rd, input logic [4:0] addr, input logic [15:0] data);
    item_t it;
    it.rd = rd;
    it.addr = addr;
    it.data = rd ? shadow[addr] : data;
    if (!rd) shadow[addr] = data;
    exp_q.push_back(it);
    sent++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_addr = addr; req_wdata = data;
    @(negedge clk);
    check(!req_ready, "R9", "ready after accept", req_ready, 0);
    req_valid = 1'b0;
    req_wdata = 16'hDEAD;
  endtask

  task summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      pmem[i] = preset(i);
      shadow[i] = preset(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    check(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    check(sclk == 1'b0, "R8", "clock idle low", sclk, 0);
    check(sle == 1'b0 && rsp_done == 1'b0, "R4", "strobe and done low", {sle, rsp_done}, 0);
    check(sdat_oe == 1'b1, "R5", "master owns line when idle", sdat_oe, 1);

    send(1'b0, 5'd0,  16'hA5C3);
    send(1'b0, 5'd31, 16'hFFFF);
    send(1'b0, 5'd5,  16'h0000);
    send(1'b1, 5'd31, 16'h0);
    send(1'b1, 5'd0,  16'h0);
    send(1'b1, 5'd17, 16'h0);   // R7: both end bits set
    send(1'b1, 5'd12, 16'h0);
    send(1'b0, 5'd12, 16'h5555);
    send(1'b1, 5'd12, 16'h0);
    send(1'b0, 5'd16, 16'hAAAA);
    send(1'b1, 5'd16, 16'h0);
    send(1'b1, 5'd5,  16'h0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(done_cnt == sent, "R9", "one done per command", done_cnt, sent);
    check(sclk == 1'b0 && sdat_oe == 1'b1, "R8", "idle after traffic", {sclk, sdat_oe}, 1);
    summary();
    $finish;
  end
endmodule